// File: doc/BRIEF.md
# Iterative Unsigned Multiply/Divide Sequencer

This block computes either a full-width unsigned product of two W-bit words or an unsigned division of a 2W-bit dividend by a W-bit divisor. It does this by running one shared step datapath W times over a three-word register stack. The three words are a top word, a second word and a third word. A multiply step is a conditional add followed by a right shift across top:second. A divide step is a left shift of top:second followed by a conditional subtract of the third word, and the quotient bit enters at the bottom of the second word.

A caller presents operands together with a one-cycle `start_i` and the operation select `op_i`. It then waits for the single-cycle `done_o` pulse. At the end of a run the third word is dropped. For a divide the top and second words are also exchanged, and the two surviving words are written to the registered result ports. The result ports hold their values until the next run completes.

Top module: `muldiv_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `busy_o`, `done_o` and `ovf_o` are 0. After reset `res_hi_o` and `res_lo_o` read 0.
- R2: With `op_i`=0 (multiply), the result satisfies {`res_hi_o`,`res_lo_o`} = `src_lo_i` × `src_d_i` (unsigned). `src_hi_i` has no effect on the result.
- R3: With `op_i`=1 (divide) and `src_hi_i` < `src_d_i`, `res_lo_o` is the quotient and `res_hi_o` is the remainder of {`src_hi_i`,`src_lo_i`} ÷ `src_d_i`.
- R4: `ovf_o` is 1 after a divide whose divisor is less than or equal to `src_hi_i`, and this includes a divisor of 0. `ovf_o` is 0 after any multiply and after any divide without overflow.
- R5: `done_o` is high for exactly one cycle, at the 18th rising edge when the edge that samples `start_i` counts as the first (for W=16). `busy_o` is high from the edge after the accepting edge up to that point, and it is never high together with `done_o`.
- R6: A `start_i` that arrives while `busy_o` is high is ignored. The run in progress keeps its operands and its timing.
- R7: `res_hi_o`, `res_lo_o` and `ovf_o` change only in the cycle in which `done_o` is high. They stay stable otherwise, including during a later run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| op_i | input | 1 | 0 = multiply, 1 = divide |
| src_hi_i | input | W | High dividend word (unused for multiply) |
| src_lo_i | input | W | Low dividend word, or multiplier |
| src_d_i | input | W | Divisor, or multiplicand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_hi_o | output | W | High product word, or remainder |
| res_lo_o | output | W | Low product word, or quotient |
| ovf_o | output | 1 | Divide quotient does not fit in W bits |

## Verification
The bench builds the block with the default W=16. With that width the 32-bit products and the 32-by-16 quotients and remainders can be computed directly in the bench's native integer arithmetic. Full-scale corners such as FFFF×FFFF and a dividend just below overflow with divisor FFFF are therefore easy to reach. Those corners make every one of the 16 steps carry or subtract, and the 18-cycle latency stays short enough to measure edge by edge for every operation.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } op_sel_t;
endpackage

// File: rtl/muldiv_step.sv
// One iteration of shift-add multiply or shift-subtract divide over the
// top/second/third stack words. Purely combinational.
module muldiv_step #(
  parameter int W = 16
) (
  input  logic         div_i,
  input  logic [W-1:0] t_i,
  input  logic [W-1:0] n_i,
  input  logic [W-1:0] n2_i,
  output logic [W-1:0] t_o,
  output logic [W-1:0] n_o
);
  logic [W:0]   sum;
  logic [W:0]   shl;
  logic [W-1:0] diff;

  always_comb begin
    // multiply: add third word when the bit leaving the second word is 1
    sum  = {1'b0, t_i} + (n_i[0] ? {1'b0, n2_i} : '0);
    // divide: shift top:second left by one, compare W+1 bits with divisor
    shl  = {t_i, n_i[W-1]};
    diff = shl[W-1:0] - n2_i;
    if (div_i) begin
      if (shl >= {1'b0, n2_i}) begin
        t_o = diff;
        n_o = {n_i[W-2:0], 1'b1};
      end else begin
        t_o = shl[W-1:0];
        n_o = {n_i[W-2:0], 1'b0};
      end
    end else begin
      t_o = sum[W:1];
      n_o = {sum[0], n_i[W-1:1]};
    end
  end
endmodule

// File: rtl/muldiv_ctr.sv
// Step counter: flags the last of STEPS enabled cycles.
module muldiv_ctr #(
  parameter int STEPS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = en_i && (cnt_q == CW'(STEPS - 1));
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         op_i,
  input  logic [W-1:0] src_hi_i,
  input  logic [W-1:0] src_lo_i,
  input  logic [W-1:0] src_d_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] res_hi_o,
  output logic [W-1:0] res_lo_o,
  output logic         ovf_o
);
  localparam int STEPS = W;

  seq_state_t   state_q;
  logic [W-1:0] t_q, n_q, n2_q;
  logic [W-1:0] t_nx, n_nx;
  logic         div_q, ovf_pend_q;
  logic         busy_q, done_q, ovf_q;
  logic [W-1:0] res_hi_q, res_lo_q;
  logic         accept, stepping, last_step;
  logic [W-1:0] fin_top, fin_next;

  assign accept   = start_i && (state_q == ST_IDLE);
  assign stepping = (state_q == ST_RUN);

  muldiv_step #(.W(W)) step_i (
    .div_i (div_q),
    .t_i   (t_q),
    .n_i   (n_q),
    .n2_i  (n2_q),
    .t_o   (t_nx),
    .n_o   (n_nx)
  );

  muldiv_ctr #(.STEPS(STEPS)) ctr_i (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (accept),
    .en_i   (stepping),
    .last_o (last_step)
  );

  // Final reorder: drop third word; divide also exchanges top and second.
  always_comb begin
    if (div_q) begin
      fin_top  = n_q;   // quotient
      fin_next = t_q;   // remainder
    end else begin
      fin_top  = t_q;   // high product
      fin_next = n_q;   // low product
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      t_q        <= '0;
      n_q        <= '0;
      n2_q       <= '0;
      div_q      <= 1'b0;
      ovf_pend_q <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      ovf_q      <= 1'b0;
      res_hi_q   <= '0;
      res_lo_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            div_q  <= (op_sel_t'(op_i) == OP_DIV);
            busy_q <= 1'b1;
            n2_q   <= src_d_i;
            n_q    <= src_lo_i;
            if (op_sel_t'(op_i) == OP_DIV) begin
              t_q        <= src_hi_i;
              ovf_pend_q <= (src_d_i <= src_hi_i);
            end else begin
              t_q        <= '0;
              ovf_pend_q <= 1'b0;
            end
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          t_q <= t_nx;
          n_q <= n_nx;
          if (last_step) state_q <= ST_FIN;
        end
        ST_FIN: begin
          if (div_q) begin
            res_lo_q <= fin_top;
            res_hi_q <= fin_next;
          end else begin
            res_hi_q <= fin_top;
            res_lo_q <= fin_next;
          end
          ovf_q   <= ovf_pend_q;
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign ovf_o    = ovf_q;
  assign res_hi_o = res_hi_q;
  assign res_lo_o = res_lo_q;
endmodule

// File: rtl/muldiv_seq_chk.sv
module muldiv_seq_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         ovf_o,
  input logic [W-1:0] res_hi_o,
  input logic [W-1:0] res_lo_o
);
  localparam int LAT = W + 2;
  localparam int LW  = $clog2(LAT + 2) + 1;
  logic [LW-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst)                   lat_q <= '0;
    else if (start_i && !busy_o && !(lat_q != 0 && !done_o && lat_q < LW'(LAT))) lat_q <= 1;
    else if (busy_o)           lat_q <= lat_q + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && !ovf_o));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  // R5
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (lat_q == LW'(LAT)));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (busy_o || done_o));

  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(res_hi_o) || !$stable(res_lo_o) || !$stable(ovf_o)) |-> done_o);
endmodule

bind muldiv_seq muldiv_seq_chk #(.W(W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .ovf_o    (ovf_o),
  .res_hi_o (res_hi_o),
  .res_lo_o (res_lo_o)
);

// File: tb/muldiv_seq_tb.sv
module muldiv_seq_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         op_i = 1'b0;
  logic [W-1:0] src_hi_i = '0, src_lo_i = '0, src_d_i = '0;
  logic         busy_o, done_o, ovf_o;
  logic [W-1:0] res_hi_o, res_lo_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  muldiv_seq #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
    .src_hi_i(src_hi_i), .src_lo_i(src_lo_i), .src_d_i(src_d_i),
    .busy_o(busy_o), .done_o(done_o),
    .res_hi_o(res_hi_o), .res_lo_o(res_lo_o), .ovf_o(ovf_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Launch one operation and wait for done; returns edge count to done.
  // inject_k > 0: drive a second start with other operands at that cycle.
  task automatic run_op(input logic op, input logic [W-1:0] hi, input logic [W-1:0] lo,
                        input logic [W-1:0] d, input int inject_k, output int lat);
    bit busy_ok = 1'b1;
    @(negedge clk);
    op_i = op; src_hi_i = hi; src_lo_i = lo; src_d_i = d; start_i = 1'b1;
    lat = -1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      start_i = (k == inject_k);
      if (k == inject_k) begin
        op_i = ~op; src_hi_i = 16'h0001; src_lo_i = 16'h7777; src_d_i = 16'h0003;
      end
      if (done_o) begin lat = k; break; end
      if (!busy_o) busy_ok = 1'b0;
    end
    start_i = 1'b0;
    check("R5 busy during run", 64'(busy_ok), 64'd1);
    check("R5 latency", 64'(lat), 64'd18);
    check("R5 busy low with done", 64'(busy_o), 64'd0);
    @(negedge clk);
    check("R5 done single pulse", 64'(done_o), 64'd0);
  endtask

  task automatic t_mul(input logic [W-1:0] hi, input logic [W-1:0] a, input logic [W-1:0] b);
    int lat;
    logic [31:0] exp_p;
    exp_p = 32'(a) * 32'(b);
    run_op(1'b0, hi, a, b, 0, lat);
    check("R2 product", 64'({res_hi_o, res_lo_o}), 64'(exp_p));
    check("R4 mul no ovf", 64'(ovf_o), 64'd0);
  endtask

  task automatic t_div(input logic [W-1:0] hi, input logic [W-1:0] lo, input logic [W-1:0] d);
    int lat;
    logic [31:0] num;
    num = {hi, lo};
    run_op(1'b1, hi, lo, d, 0, lat);
    check("R3 quotient", 64'(res_lo_o), 64'(num / 32'(d)));
    check("R3 remainder", 64'(res_hi_o), 64'(num % 32'(d)));
    check("R4 div no ovf", 64'(ovf_o), 64'd0);
  endtask

  task automatic t_ovf(input logic [W-1:0] hi, input logic [W-1:0] d);
    int lat;
    run_op(1'b1, hi, 16'h1234, d, 0, lat);
    check("R4 ovf set", 64'(ovf_o), 64'd1);
  endtask

  task automatic t_ignore_start();
    int lat;
    run_op(1'b0, 16'h0000, 16'h0101, 16'h0202, 5, lat);
    check("R6 ignored start product", 64'({res_hi_o, res_lo_o}), 64'(32'h0101 * 32'h0202));
    @(negedge clk);
    check("R6 no extra run", 64'(busy_o), 64'd0);
  endtask

  task automatic t_hold();
    logic [2*W-1:0] r;
    logic o;
    r = {res_hi_o, res_lo_o}; o = ovf_o;
    // new operands with no start
    src_hi_i = 16'hAAAA; src_lo_i = 16'h5555; src_d_i = 16'h0001;
    repeat (10) @(negedge clk);
    check("R7 hold idle", 64'({res_hi_o, res_lo_o, ovf_o}), 64'({r, o}));
    // start a run, check mid-run hold
    @(negedge clk);
    op_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (8) @(negedge clk);
    check("R7 hold mid run", 64'({res_hi_o, res_lo_o, ovf_o}), 64'({r, o}));
    repeat (12) @(negedge clk);
  endtask

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset busy", 64'(busy_o), 64'd0);
    check("R1 reset done", 64'(done_o), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 64'({busy_o, done_o, ovf_o, res_hi_o, res_lo_o}), 64'd0);

    t_mul(16'hBEEF, 16'h1234, 16'h5678);
    t_mul(16'h0000, 16'hFFFF, 16'hFFFF);
    t_mul(16'h0000, 16'h0000, 16'hABCD);
    t_mul(16'hFFFF, 16'h8001, 16'h0001);
    t_div(16'h1234, 16'h5678, 16'h9ABC);
    t_div(16'hFFFE, 16'hFFFF, 16'hFFFF);
    t_div(16'h0000, 16'h0004, 16'h0002);
    t_div(16'h0000, 16'h0007, 16'h0001);
    t_ovf(16'h0005, 16'h0005);
    t_ovf(16'h0000, 16'h0000);
    t_ovf(16'hFFFF, 16'h1000);
    t_mul(16'h0000, 16'h0003, 16'h0005);
    t_ignore_start();
    t_hold();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule